// File: doc/BRIEF.md
# Four-Channel Square Tone Generator

This block produces a mixed square-wave audio sample from four independent tone channels. Each channel owns a 16-bit period register and a 16-bit down-counter; each time the counter steps from 1 to 0 the channel's square wave changes level, and on the following counting step the counter reloads from the period register. A channel whose period register holds 0 is parked at the high (positive) level.

Software programs the block through a simple write-only port bus: a write strobe, an 8-bit port address and 16-bit data. Four ports set the channel periods. Two ports each hold a pair of 4-bit volumes. The output sample is the unsigned sum of the volumes of all channels that are at the high level. A clock-enable input paces the counters, so a prescaled tick can set the pitch range.

Top module: `quad_tone_gen`

## Requirements
- R1: While reset is asserted and right after it, every period register, volume register and counter is 0, every channel level (`chanPos`) is 1 and `mixOut` is 0.
- R2: A write to port 4, 5, 6 or 7 loads all 16 data bits into the period register of channel A, B, C or D respectively (channel index 0..3), effective from the next clock.
- R3: On a clock where `tickEn` is 1 and a channel's counter is 0, the counter loads that channel's period register; otherwise with `tickEn` high it decrements by one.
- R4: A channel's level inverts exactly when its counter steps from 1 to 0 under `tickEn` and its period register is nonzero, so a period value N>0 yields a level change every N+1 ticks.
- R5: While a channel's period register is 0, its level is driven to 1 on the next clock, regardless of `tickEn` and of the counter.
- R6: With `tickEn` low, no counter changes and no level changes (apart from the forcing of R5).
- R7: A write to port 8 sets volume A from data bits 3:0 and volume B from bits 7:4; port 9 sets volume C from bits 3:0 and volume D from bits 7:4. Data bits 15:8 have no effect.
- R8: `mixOut` is the 6-bit unsigned sum, over the four channels, of the channel's volume when its level is 1 and 0 when it is 0; it follows the registered state without further delay.
- R9: Writes to any port other than 4 to 9 change no register and no output.
- R10: A period write does not disturb a running counter; the counter uses the new value only at its next reload, and a write on the same clock as a reload loads the old value into the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Counter step enable |
| wrEn | input | 1 | Port write strobe |
| wrAddr | input | 8 | Port address |
| wrData | input | 16 | Port write data |
| chanPos | output | 4 | Level of each channel (bit 0 = A), 1 = high |
| mixOut | output | 6 | Mixed unsigned sample |

## Verification
The collision that matters is a period write landing on the very clock a channel's counter sits at 0 and reloads: the counter must take the old period while the register takes the new one. The bench provokes this by watching its own model's counter and issuing the write exactly when that counter is 0, and likewise writes a period of 0 while a channel is low so the force and the countdown meet; in both cases the level pattern and the mix are compared every cycle against the behavioural model, so a wrong choice shows up as a shifted level change one period later.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int TONE_CH  = 4;   // number of channels
  localparam int TONE_CW  = 16;  // counter / period width
  localparam int TONE_VW  = 4;   // volume width
  localparam int TONE_AW  = 8;   // port address width
  localparam int TONE_DW  = 16;  // port data width
  localparam int TONE_VP  = TONE_CH / 2;  // volume ports, two channels each
  localparam int TONE_FREQ_BASE = 4;
  localparam int TONE_VOL_BASE  = 8;

  typedef struct packed {
    logic [TONE_CH-1:0] freqWe;
    logic [TONE_VP-1:0] volWe;
    logic [TONE_DW-1:0] data;
  } tone_strobe_t;
endpackage

// File: rtl/tone_ctrl.sv
module tone_ctrl
  import tone_pkg::*;
#(
  parameter int NUM_CH    = TONE_CH,
  parameter int ADDR_W    = TONE_AW,
  parameter int DATA_W    = TONE_DW,
  parameter int FREQ_BASE = TONE_FREQ_BASE,
  parameter int VOL_BASE  = TONE_VOL_BASE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output tone_strobe_t      strobe
);
  localparam int NUM_VP = NUM_CH / 2;

  logic [NUM_CH-1:0] freqHit;
  logic [NUM_VP-1:0] volHit;

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CH; gc++) begin : g_freq
      assign freqHit[gc] = wrEn && (wrAddr == ADDR_W'(FREQ_BASE + gc));
    end
    for (gc = 0; gc < NUM_VP; gc++) begin : g_vol
      assign volHit[gc] = wrEn && (wrAddr == ADDR_W'(VOL_BASE + gc));
    end
  endgenerate

  always_comb begin
    strobe        = '0;
    strobe.freqWe = freqHit;
    strobe.volWe  = volHit;
    strobe.data   = wrData;
  end

  // R9: a write outside the mapped window raises no strobe
  a_r9_unmapped_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (int'(wrAddr) < FREQ_BASE || int'(wrAddr) >= VOL_BASE + NUM_VP))
      |-> (strobe.freqWe == '0 && strobe.volWe == '0));

  // R2: at most one register is targeted per write
  a_r2_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.freqWe, strobe.volWe}));
endmodule

// File: rtl/tone_channel.sv
module tone_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             freqWe,
  input  logic [CNT_W-1:0] freqData,
  output logic             posOut
);
  logic [CNT_W-1:0] freqQ;
  logic [CNT_W-1:0] cntQ;
  logic             posQ;
  logic [CNT_W-1:0] cntNext;
  logic             posNext;

  always_comb begin
    cntNext = cntQ;
    posNext = posQ;
    if (tickEn) begin
      if (cntQ == '0) begin
        cntNext = freqQ;
      end else begin
        cntNext = cntQ - 1'b1;
        if (cntQ == CNT_W'(1)) posNext = ~posQ;
      end
    end
    if (freqQ == '0) posNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freqQ <= '0;
      cntQ  <= '0;
      posQ  <= 1'b1;
    end else begin
      cntQ <= cntNext;
      posQ <= posNext;
      if (freqWe) freqQ <= freqData;
    end
  end

  assign posOut = posQ;

  // R3: a zero counter reloads from the period held on that clock
  a_r3_reload: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && cntQ == '0) |=> (cntQ == $past(freqQ)));

  // R4: level flips on the 1-to-0 step of an active channel
  a_r4_flip: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && cntQ == CNT_W'(1) && freqQ != '0) |=> (posQ != $past(posQ)));

  // R5: a zero period parks the level high
  a_r5_park_high: assert property (@(posedge clk) disable iff (!rstN)
    (freqQ == '0) |=> posQ);

  // R6: no stepping without the enable
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && freqQ != '0) |=> ($stable(cntQ) && $stable(posQ)));

  // R2: a period write lands in the register
  a_r2_freq_load: assert property (@(posedge clk) disable iff (!rstN)
    freqWe |=> (freqQ == $past(freqData)));
endmodule

// File: rtl/tone_datapath.sv
module tone_datapath
  import tone_pkg::*;
#(
  parameter int NUM_CH = TONE_CH,
  parameter int CNT_W  = TONE_CW,
  parameter int VOL_W  = TONE_VW,
  parameter int MIX_W  = TONE_VW + $clog2(TONE_CH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickEn,
  input  tone_strobe_t       strobe,
  output logic [NUM_CH-1:0]  chanPos,
  output logic [MIX_W-1:0]   mixOut
);
  localparam int NUM_VP = NUM_CH / 2;

  logic [VOL_W-1:0] volQ [NUM_CH];
  logic [MIX_W-1:0] mixSum;

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CH; gc++) begin : g_chan
      tone_channel #(.CNT_W(CNT_W)) u_chan (
        .clk     (clk),
        .rstN    (rstN),
        .tickEn  (tickEn),
        .freqWe  (strobe.freqWe[gc]),
        .freqData(strobe.data[CNT_W-1:0]),
        .posOut  (chanPos[gc])
      );
    end

    for (gc = 0; gc < NUM_VP; gc++) begin : g_volreg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          volQ[2*gc]   <= '0;
          volQ[2*gc+1] <= '0;
        end else if (strobe.volWe[gc]) begin
          volQ[2*gc]   <= strobe.data[VOL_W-1:0];
          volQ[2*gc+1] <= strobe.data[2*VOL_W-1:VOL_W];
        end
      end
    end
  endgenerate

  always_comb begin
    mixSum = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chanPos[i]) mixSum = mixSum + MIX_W'(volQ[i]);
    end
  end

  assign mixOut = mixSum;

  // R7: lower nibble of a pair-port write reaches the even channel
  a_r7_vol_low: assert property (@(posedge clk) disable iff (!rstN)
    strobe.volWe[0] |=> (volQ[0] == $past(strobe.data[VOL_W-1:0])));

  // R8: all channels low means silence
  a_r8_silent: assert property (@(posedge clk) disable iff (!rstN)
    (chanPos == '0) |-> (mixOut == '0));
endmodule

// File: rtl/quad_tone_gen.sv
module quad_tone_gen
  import tone_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic         wrEn,
  input  logic [7:0]   wrAddr,
  input  logic [15:0]  wrData,
  output logic [3:0]   chanPos,
  output logic [5:0]   mixOut
);
  tone_strobe_t strobe;

  tone_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .strobe(strobe)
  );

  tone_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .tickEn (tickEn),
    .strobe (strobe),
    .chanPos(chanPos),
    .mixOut (mixOut)
  );
endmodule

// File: tb/sim_quad_tone_gen.sv
`timescale 1ns/1ps
module sim_quad_tone_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [3:0]  chanPos;
  logic [5:0]  mixOut;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";
  bit finished = 1'b0;

  // behavioural model state
  int mFreq [4] = '{0, 0, 0, 0};
  int mCnt  [4] = '{0, 0, 0, 0};
  int mVol  [4] = '{0, 0, 0, 0};
  bit mPos  [4] = '{1, 1, 1, 1};

  always #4 clk = ~clk;  // 125 MHz

  quad_tone_gen u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .chanPos(chanPos), .mixOut(mixOut)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < 4; c++) begin
        mFreq[c] = 0; mCnt[c] = 0; mVol[c] = 0; mPos[c] = 1;
      end
    end else begin
      for (int c = 0; c < 4; c++) begin
        if (tickEn) begin
          if (mCnt[c] == 0) mCnt[c] = mFreq[c];
          else begin
            if (mCnt[c] == 1) mPos[c] = !mPos[c];
            mCnt[c] = mCnt[c] - 1;
          end
        end
        if (mFreq[c] == 0) mPos[c] = 1;
      end
      if (wrEn) begin
        if (wrAddr >= 4 && wrAddr <= 7) mFreq[wrAddr - 4] = int'(wrData);
        else if (wrAddr == 8) begin
          mVol[0] = int'(wrData[3:0]); mVol[1] = int'(wrData[7:4]);
        end else if (wrAddr == 9) begin
          mVol[2] = int'(wrData[3:0]); mVol[3] = int'(wrData[7:4]);
        end
      end
    end
  end

  always @(negedge clk) begin
    logic [3:0] expPos;
    int expMix;
    expMix = 0;
    for (int c = 0; c < 4; c++) begin
      expPos[c] = mPos[c];
      if (mPos[c]) expMix += mVol[c];
    end
    compared++;
    if (chanPos !== expPos || int'(mixOut) !== expMix) begin
      mismatched++;
      $display("FAIL %s t=%0t chanPos=%b exp=%b mixOut=%0d exp=%0d",
               curReq, $time, chanPos, expPos, mixOut, expMix);
    end
  end

  task automatic portWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    curReq = "R1";
    idle(3);
    rstN = 1'b1;
    idle(3);

    curReq = "R7";  // upper data bits must not matter
    portWrite(8'd8, 16'hFFA5);
    portWrite(8'd9, 16'h003C);
    idle(2);

    curReq = "R2";
    portWrite(8'd4, 16'd3);
    portWrite(8'd5, 16'd5);
    portWrite(8'd6, 16'd1);
    portWrite(8'd7, 16'd0);
    @(negedge clk);
    tickEn = 1'b1;
    curReq = "R4";
    idle(40);
    curReq = "R3";
    idle(20);

    curReq = "R6";
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      tickEn = ((i * 7) % 5) < 2;
    end
    tickEn = 1'b1;

    curReq = "R10";  // write while counter runs mid-count
    @(negedge clk);
    while (mCnt[1] < 2) @(negedge clk);
    portWrite(8'd5, 16'd2);
    idle(30);
    // write coinciding with a reload of channel A
    while (mCnt[0] != 0) @(negedge clk);
    wrEn = 1'b1; wrAddr = 8'd4; wrData = 16'd6;
    @(negedge clk);
    wrEn = 1'b0;
    idle(40);

    curReq = "R5";
    while (mPos[1] != 0) @(negedge clk);
    wrEn = 1'b1; wrAddr = 8'd5; wrData = 16'd0;
    @(negedge clk);
    wrEn = 1'b0;
    tickEn = 1'b0;
    idle(5);
    tickEn = 1'b1;
    idle(20);

    curReq = "R9";
    portWrite(8'd0, 16'h0001);
    portWrite(8'd3, 16'h00FF);
    portWrite(8'd10, 16'hFFFF);
    portWrite(8'd255, 16'h1234);
    portWrite(8'd12, 16'h0000);
    idle(20);

    curReq = "R8";
    portWrite(8'd8, 16'h00FF);
    portWrite(8'd9, 16'h00FF);
    portWrite(8'd7, 16'd4);
    idle(60);
    portWrite(8'd9, 16'h0010);
    idle(30);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog %s expired actual=running expected=done", curReq);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule